// File: doc/BRIEF.md
# Pipelined SAR ADC Channel Reader

This block is a controller for a multichannel successive-approximation converter on an SPI link. A client asks for one channel through a valid/ready handshake. The controller then runs the SPI frames needed for that channel and returns the conversion code, right-justified, together with a one-cycle done pulse. The converter's output always lags its configuration by two frames: the data shifted out in a frame was converted under the configuration word written two frames before. The controller hides this lag.

The controller keeps a 14-bit shadow of the converter's configuration word. Every frame sends this shadow, placed in the top 14 bits of a 16-bit word. A read puts the requested channel into the channel field of the shadow and sends it. If the channel differs from the channel of the previous completed read, a second priming frame follows. A final frame then captures the valid result. When the channel has not changed, the pipeline already holds a conversion of that channel, so one priming frame is skipped.

Between any two frames there is a minimum idle gap, counted in system clocks. After reset the controller writes a fixed start-up word and performs two dummy reads of channel 0 before it accepts any request. A debug port replaces the whole shadow word and shows the shadow at all times.

Top module: `adc_chan_reader`

## Requirements
- R1: During reset and after it, the shadow word is the start-up value. That value has bit 13 = 1, bits 12:10 = 7, bits 9:7 = 0, bit 6 = 1, bits 5:3 = REF_SEL, bits 2:1 = 0 and bit 0 = 1. After reset exactly five frames carrying this word are run, and only then does `req_ready` rise.
- R2: Each frame is SPI mode 0 with 16 bits, MSB first. `cs_n` is low for the whole frame and `sclk` is low whenever `cs_n` is high. The word sent is the shadow shifted left by 2.
- R3: The result is the received 16-bit word shifted right by 16 - RES. It appears on `rsp_data` with a `rsp_done` pulse that lasts exactly one cycle.
- R4: A read of a channel other than the last channel read runs three frames. Each of these frames carries the shadow with bits 9:7 equal to the requested channel.
- R5: A read of the same channel as the last channel read runs two frames.
- R6: Between the rising edge of `cs_n` and the next falling edge there are at least GAP_US * CYC_PER_US system clocks.
- R7: `req_ready` is high only while the controller is idle and `dbg_we` is low. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response.
- R8: The last-channel register is 0 after reset and changes only in the cycle the result is delivered.
- R9: A debug write made while the controller is idle replaces all 14 shadow bits and runs one frame carrying them. A debug write made while the controller is busy is ignored. `dbg_rdata` always shows the shadow.
- R10: A read changes only bits 9:7 of the shadow. All other bits keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_chan | input | $clog2(NCH) | Channel to read |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_data | output | RES | Right-justified conversion code |
| dbg_we | input | 1 | Debug write of the shadow word |
| dbg_wdata | input | 14 | Debug write value |
| dbg_rdata | output | 14 | Current shadow word |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |

## Verification
The hardest case to reach is a result that is correct only because the two-frame lag was handled properly. It arises when a read reuses the previous channel and takes the two-frame shortcut, and the code it returns was converted during the final frame of the previous read. A converter model in the bench is needed to expose this. The model returns codes that depend on the channel, taken from the configuration it received two frames earlier. The request table alternates repeated and changed channels, so that skipping a frame or adding one returns the wrong code. Debug writes are also driven in the middle of a read, to show that the shadow is left unchanged.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int CFG_W   = 14;
    localparam int FRAME_W = 16;
    localparam int CH_LSB  = 7;
    localparam int CH_W    = 3;

    typedef enum logic [1:0] {
        CT_IDLE   = 2'd0,
        CT_LAUNCH = 2'd1,
        CT_WAIT   = 2'd2
    } ctl_state_e;

    function automatic logic [CFG_W-1:0] startup_cfg(input logic [2:0] ref_sel);
        return {1'b1, 3'd7, 3'd0, 1'b1, ref_sel, 2'b00, 1'b1};
    endfunction

endpackage

// File: rtl/adc_spi_shifter.sv
module adc_spi_shifter #(
    parameter int FRAME_W = 16,
    parameter int DIV     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_word,
    output logic [FRAME_W-1:0] rx_word,
    output logic               done,
    output logic               idle,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    input  logic               miso
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BW = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic               sclk;
        logic               cs_n;
        logic               done;
        logic [DW-1:0]      div;
        logic [BW-1:0]      bitn;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.cs_n = 1'b0;
                s_d.sclk = 1'b0;
                s_d.div  = '0;
                s_d.bitn = '0;
                s_d.tx   = tx_word;
                s_d.rx   = '0;
            end
        end else if (s_q.div == DW'(DIV - 1)) begin
            s_d.div = '0;
            if (!s_q.sclk) begin
                s_d.sclk = 1'b1;
                s_d.rx   = {s_q.rx[FRAME_W-2:0], miso};
            end else begin
                s_d.sclk = 1'b0;
                if (s_q.bitn == BW'(FRAME_W - 1)) begin
                    s_d.busy = 1'b0;
                    s_d.cs_n = 1'b1;
                    s_d.done = 1'b1;
                end else begin
                    s_d.bitn = s_q.bitn + BW'(1);
                    s_d.tx   = {s_q.tx[FRAME_W-2:0], 1'b0};
                end
            end
        end else begin
            s_d.div = s_q.div + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_word = s_q.rx;
    assign done    = s_q.done;
    assign idle    = !s_q.busy;
    assign sclk    = s_q.sclk;
    assign cs_n    = s_q.cs_n;
    assign mosi    = s_q.tx[FRAME_W-1];

    // R2: clock parked low outside a frame
    p_sclk_low_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R2: chip select stays low from one cycle to the next until the frame ends
    p_cs_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !done) |=> (!cs_n || done));

endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
    parameter int GAP_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy
);
    localparam int GW = $clog2(GAP_CYC + 1);

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig) begin
            cnt_d = GW'(GAP_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - GW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R6: a trigger always opens a busy window
    p_gap_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> busy);

endmodule

// File: rtl/adc_chan_reader.sv
module adc_chan_reader
    import adc_rd_pkg::*;
#(
    parameter int          RES        = 16,
    parameter int          NCH        = 8,
    parameter int          SCLK_DIV   = 2,
    parameter int          CYC_PER_US = 4,
    parameter int          GAP_US     = 2,
    parameter logic [2:0]  REF_SEL    = 3'd1,
    localparam int         CHW        = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CHW-1:0]   req_chan,
    output logic             rsp_done,
    output logic [RES-1:0]   rsp_data,
    input  logic             dbg_we,
    input  logic [CFG_W-1:0] dbg_wdata,
    output logic [CFG_W-1:0] dbg_rdata,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    localparam int GAP_CYC    = GAP_US * CYC_PER_US;
    localparam int PAD        = FRAME_W - RES;
    localparam int INIT_FRAMES = 5;

    typedef struct packed {
        ctl_state_e       st;
        logic [CFG_W-1:0] cfg;
        logic [CHW-1:0]   last_ch;
        logic [CHW-1:0]   cur_ch;
        logic [2:0]       left;
        logic             is_read;
        logic             start;
        logic             done;
        logic [RES-1:0]   data;
    } ctl_t;

    ctl_t c_d, c_q;

    logic               shf_idle, shf_done, gap_busy;
    logic [FRAME_W-1:0] shf_rx;
    logic               accept;

    assign req_ready = (c_q.st == CT_IDLE) && !dbg_we;
    assign accept    = req_valid && req_ready;

    always_comb begin
        c_d       = c_q;
        c_d.start = 1'b0;
        c_d.done  = 1'b0;
        unique case (c_q.st)
            CT_IDLE: begin
                if (dbg_we) begin
                    c_d.cfg     = dbg_wdata;
                    c_d.left    = 3'd1;
                    c_d.is_read = 1'b0;
                    c_d.st      = CT_LAUNCH;
                end else if (req_valid) begin
                    c_d.cfg[CH_LSB +: CH_W] = CH_W'(req_chan);
                    c_d.cur_ch  = req_chan;
                    c_d.left    = (req_chan == c_q.last_ch) ? 3'd2 : 3'd3;
                    c_d.is_read = 1'b1;
                    c_d.st      = CT_LAUNCH;
                end
            end
            CT_LAUNCH: begin
                if (shf_idle && !gap_busy) begin
                    c_d.start = 1'b1;
                    c_d.st    = CT_WAIT;
                end
            end
            CT_WAIT: begin
                if (shf_done) begin
                    if (c_q.left == 3'd1) begin
                        c_d.st = CT_IDLE;
                        if (c_q.is_read) begin
                            c_d.data    = RES'(shf_rx >> PAD);
                            c_d.done    = 1'b1;
                            c_d.last_ch = c_q.cur_ch;
                        end
                    end else begin
                        c_d.left = c_q.left - 3'd1;
                        c_d.st   = CT_LAUNCH;
                    end
                end
            end
            default: c_d.st = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= CT_LAUNCH;
            c_q.cfg  <= startup_cfg(REF_SEL);
            c_q.left <= 3'(INIT_FRAMES);
        end else begin
            c_q <= c_d;
        end
    end

    adc_spi_shifter #(
        .FRAME_W (FRAME_W),
        .DIV     (SCLK_DIV)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (c_q.start),
        .tx_word ({c_q.cfg, 2'b00}),
        .rx_word (shf_rx),
        .done    (shf_done),
        .idle    (shf_idle),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .miso    (miso)
    );

    adc_gap_timer #(
        .GAP_CYC (GAP_CYC)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (shf_done),
        .busy  (gap_busy)
    );

    assign rsp_done  = c_q.done;
    assign rsp_data  = c_q.data;
    assign dbg_rdata = c_q.cfg;

    // R6: no frame is launched inside the idle gap
    p_start_after_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.start |-> (!gap_busy && shf_idle));
    // R3: the result strobe lasts one cycle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R7: after acceptance the controller is busy
    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    // R9: shadow is frozen while a frame is on the wire
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(dbg_rdata));
    // R8: last channel moves only together with the result
    p_last_ch_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.last_ch != $past(c_q.last_ch)) |-> rsp_done);

endmodule

// File: tb/adc_chan_reader_bench.sv
module adc_chan_reader_bench;
    localparam int RES = 16;
    localparam int NCH = 8;
    localparam int CPU = 4;
    localparam int GAP = 2 * CPU;
    localparam logic [2:0] REFS = 3'd1;
    localparam logic [13:0] INIT_CFG =
        (14'd1 << 13) | (14'd7 << 10) | (14'd1 << 6) | (14'(REFS) << 3) | 14'd1;

    localparam int NV = 7;
    localparam int TBL_CH [NV] = '{0, 3, 3, 7, 1, 1, 0};
    localparam int TBL_FR [NV] = '{2, 3, 2, 3, 3, 2, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_chan = '0;
    logic rsp_done;
    logic [RES-1:0] rsp_data;
    logic dbg_we = 1'b0;
    logic [13:0] dbg_wdata = '0;
    logic [13:0] dbg_rdata;
    logic sclk, cs_n, mosi, miso;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_chan_reader #(.RES(RES), .NCH(NCH), .SCLK_DIV(2), .CYC_PER_US(CPU),
                      .GAP_US(2), .REF_SEL(REFS)) u_adc_chan_reader (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

    function automatic logic [15:0] conv_code(input int ch);
        return 16'((ch * 4951 + 291) & ((1 << RES) - 1));
    endfunction

    // converter model: output lags configuration by two frames
    logic [15:0] m_tx = '0, m_rx = '0, last_word = '0;
    logic [13:0] hist1 = '0, hist2 = '0;
    int nhist = 0, frames = 0, t_rise = 0, min_gap = 1000000;
    logic p_cs = 1'b1, p_sclk = 1'b0;
    assign miso = m_tx[15];

    always @(cs_n or sclk) begin
        if (cs_n !== p_cs) begin
            if (p_cs === 1'b1 && cs_n === 1'b0) begin
                if (frames > 0 && (cyc - t_rise) < min_gap) min_gap = cyc - t_rise;
                m_tx = (nhist >= 2) ? (conv_code(int'(hist2[9:7])) << (16 - RES)) : 16'hFFFF;
                m_rx = '0;
            end else if (p_cs === 1'b0 && cs_n === 1'b1 && rst_n) begin
                hist2 = hist1;
                hist1 = m_rx[15:2];
                nhist++;
                frames++;
                last_word = m_rx;
                t_rise = cyc;
            end
        end else if (sclk !== p_sclk && cs_n === 1'b0) begin
            if (sclk === 1'b1) m_rx = {m_rx[14:0], mosi};
            else               m_tx = {m_tx[14:0], 1'b0};
        end
        p_cs = cs_n;
        p_sclk = sclk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 20000 && !req_ready; i++) @(negedge clk);
    endtask

    task automatic do_read(input int ch, input int exp_fr, input bit poke_dbg);
        int f0;
        logic [13:0] cfg_before;
        logic [13:0] exp_cfg;
        wait_ready();
        cfg_before = dbg_rdata;
        exp_cfg = cfg_before;
        exp_cfg[9:7] = 3'(ch);
        f0 = frames;
        req_valid = 1'b1;
        req_chan = 3'(ch);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R7 busy after accept", int'(req_ready), 0);
        if (poke_dbg) begin
            @(negedge clk);
            dbg_we = 1'b1;
            dbg_wdata = 14'h0000;
            @(negedge clk);
            dbg_we = 1'b0;
        end
        for (int i = 0; i < 20000 && !rsp_done; i++) @(negedge clk);
        chk(rsp_done === 1'b1, "R3 done seen", int'(rsp_done), 1);
        chk(rsp_data == conv_code(ch), "R3 result code", int'(rsp_data), int'(conv_code(ch)));
        chk(frames - f0 == exp_fr, exp_fr == 2 ? "R5 frame count" : "R4 frame count",
            frames - f0, exp_fr);
        chk(last_word == {exp_cfg, 2'b00}, "R4 R2 word sent", int'(last_word),
            int'({exp_cfg, 2'b00}));
        chk(dbg_rdata == exp_cfg, "R10 shadow after read", int'(dbg_rdata), int'(exp_cfg));
        chk(req_ready === 1'b1, "R7 ready after response", int'(req_ready), 1);
        @(negedge clk);
        chk(!rsp_done, "R3 single pulse", int'(rsp_done), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b0, "R2 bus idle in reset", int'({cs_n, sclk}), 2);
        chk(req_ready === 1'b0, "R1 not ready in reset", int'(req_ready), 0);
        chk(dbg_rdata == INIT_CFG, "R1 startup word", int'(dbg_rdata), int'(INIT_CFG));
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b0, "R1 not ready during init", int'(req_ready), 0);
        wait_ready();
        chk(frames == 5, "R1 init frame count", frames, 5);
        chk(last_word == {INIT_CFG, 2'b00}, "R1 init word", int'(last_word),
            int'({INIT_CFG, 2'b00}));

        // table of requests: same channel as last (R5, R8) and changed (R4)
        for (int v = 0; v < NV; v++) begin
            do_read(TBL_CH[v], TBL_FR[v], 1'b0);
        end

        // R9 debug write when idle
        begin
            int f0;
            logic [13:0] w;
            w = 14'h1D12;
            wait_ready();
            f0 = frames;
            dbg_we = 1'b1;
            dbg_wdata = w;
            @(negedge clk);
            dbg_we = 1'b0;
            chk(dbg_rdata == w, "R9 shadow replaced", int'(dbg_rdata), int'(w));
            wait_ready();
            chk(frames - f0 == 1, "R9 one frame", frames - f0, 1);
            chk(last_word == {w, 2'b00}, "R9 frame word", int'(last_word), int'({w, 2'b00}));
        end

        // R10 keep other bits; R9 ignore debug write during a read
        do_read(6, 3, 1'b0);
        do_read(6, 2, 1'b1);
        do_read(2, 3, 1'b1);

        wait_ready();
        chk(min_gap >= GAP, "R6 idle gap", min_gap, GAP);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule